// File: doc/BRIEF.md
# Ring Queue Pointer Tracker

This block keeps the pointer state of a single command ring used by a DMA engine. It holds a base address and ring size taken from configuration inputs, a wrapping read offset, a wrapping write offset, a read count that never wraps, and two flags: one marks the queue as mapped and one marks it as busy. Software rings a doorbell to publish a new write offset. While the queue is mapped and entries are waiting, the block asks for the header word of the next packet at base plus read offset. It then waits until the packet consumer reports that the packet has finished, and gives the packet length in 32-bit words.

A queue can be taken off the engine and put back later. Taking it off (unmap) emits the live read and write offsets on a one-cycle save strobe, which an outside agent writes back into the queue descriptor. Putting it back (map) loads the offsets from that descriptor, so the queue resumes where it stopped and does not start again at zero. Packet decoding, memory traffic and descriptor storage are outside this block.

Top module: `ring_queue_tracker`

## Requirements
- R1: After reset, q_valid, q_busy, fetch_req and save_valid are 0, and rptr_off, wptr_off and global_rptr are 0.
- R2: A map_valid cycle loads rptr_off and global_rptr from map_rptr, loads wptr_off from map_wptr and sets q_valid on the next clock edge. A remap with the values a previous unmap saved resumes fetching at base plus the saved read offset.
- R3: A doorbell loads wptr_off with doorbell_wptr reduced modulo cfg_size. The doorbell value must be below twice cfg_size. wptr_addr always equals cfg_base plus wptr_off.
- R4: When the queue is mapped, not busy, and rptr_off differs from wptr_off, fetch_req is 1 and fetch_addr equals cfg_base plus rptr_off. q_busy is 1 from the next clock edge.
- R5: pkt_done while busy advances rptr_off by pkt_len modulo cfg_size and adds pkt_len to global_rptr with no wrap. pkt_len must be below cfg_size. pkt_done while not busy changes neither offset nor count.
- R6: A doorbell while busy raises no fetch_req. After pkt_done, the next cycle re-checks the pointers: it raises fetch_req if entries remain, and otherwise leaves q_busy at 0.
- R7: An unmap pulse gives one cycle of save_valid on the next clock edge, with save_rptr and save_wptr equal to the offsets at the unmap. q_valid and q_busy are 0 in that same cycle. The offsets keep their values.
- R8: A rptr_load cycle sets both rptr_off and global_rptr to rptr_load_val.
- R9: A doorbell on an unmapped queue updates wptr_off but raises no fetch_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | ADDR_W | Ring base address |
| cfg_size | input | OFF_W | Ring size in words, nonzero |
| map_valid | input | 1 | Map the queue, restoring offsets |
| map_rptr | input | OFF_W | Read offset to restore |
| map_wptr | input | OFF_W | Write offset to restore |
| unmap | input | 1 | Unmap pulse |
| rptr_load | input | 1 | Explicit read pointer load |
| rptr_load_val | input | OFF_W | Value for the read pointer load |
| doorbell_valid | input | 1 | Doorbell write |
| doorbell_wptr | input | OFF_W | Write offset carried by the doorbell |
| pkt_done | input | 1 | Consumer finished the current packet |
| pkt_len | input | LEN_W | Length of the finished packet in words |
| fetch_req | output | 1 | Request to fetch a packet header word |
| fetch_addr | output | ADDR_W | Header fetch address |
| wptr_addr | output | ADDR_W | Base plus write offset |
| rptr_off | output | OFF_W | Local read offset |
| wptr_off | output | OFF_W | Local write offset |
| global_rptr | output | GCNT_W | Read count, never wraps |
| q_valid | output | 1 | Queue mapped |
| q_busy | output | 1 | Packet in progress |
| save_valid | output | 1 | Save strobe for descriptor writeback |
| save_rptr | output | OFF_W | Saved read offset |
| save_wptr | output | OFF_W | Saved write offset |

## Verification
The assertions check on every cycle that:
- a fetch request leads to the busy state;
- busy without a completion raises no new fetch;
- the save strobe never coincides with a mapped or busy queue;
- the saved offsets match the offsets at the unmap;
- a completion adds exactly the packet length to the running count;
- the offsets stay inside the ring while it is mapped.

Only the bench's scenarios show the following:
- wrap arithmetic values across the ring end;
- a doorbell value reduced modulo the size;
- the exact order of fetch addresses after pointer reloads;
- resuming from saved offsets after a remap.

// File: rtl/rqt_pkg.sv
// Package: shared state encoding for the ring queue tracker.
// Assumes nothing beyond a two-state control loop.
package rqt_pkg;
    typedef enum logic [0:0] {
        FC_IDLE = 1'b0,
        FC_WAIT = 1'b1
    } fc_state_e;
endpackage

// File: rtl/rqt_modadd.sv
// Module: modular adder for ring offsets.
// Computes (a + b) mod size by one compare and one subtract.
// Assumes a + b < 2 * size, which holds when both operands are below size,
// or when b is zero and a is below twice size.
module rqt_modadd #(
    parameter int W = 12
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] size,
    output logic [W-1:0] y
);
    logic [W:0] sum;
    logic [W:0] diff;

    // Form the wide sum and its reduced form, then pick one.
    always_comb begin
        sum  = {1'b0, a} + {1'b0, b};
        diff = sum - {1'b0, size};
        y    = (sum >= {1'b0, size}) ? diff[W-1:0] : sum[W-1:0];
    end
endmodule

// File: rtl/rqt_ptr_regs.sv
// Module: pointer and flag registers of one ring queue.
// Holds the read and write offsets, the running read count, the mapped flag
// and the save strobe. Update priority on the read side is:
// unmap (freeze) > map > explicit load > packet advance.
// Update priority on the write side is: unmap (freeze) > map > doorbell.
module rqt_ptr_regs #(
    parameter int OFF_W  = 12,
    parameter int GCNT_W = 40,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_valid,
    input  logic [OFF_W-1:0]  map_rptr,
    input  logic [OFF_W-1:0]  map_wptr,
    input  logic              unmap,
    input  logic              rptr_load,
    input  logic [OFF_W-1:0]  rptr_load_val,
    input  logic              db_valid,
    input  logic [OFF_W-1:0]  db_wptr_red,
    input  logic              adv_en,
    input  logic [OFF_W-1:0]  adv_rptr,
    input  logic [LEN_W-1:0]  adv_len,
    output logic [OFF_W-1:0]  rptr,
    output logic [OFF_W-1:0]  wptr,
    output logic [GCNT_W-1:0] gcnt,
    output logic              valid,
    output logic              save_valid,
    output logic [OFF_W-1:0]  save_rptr,
    output logic [OFF_W-1:0]  save_wptr
);
    localparam int LEN_PAD = GCNT_W - LEN_W;
    localparam int OFF_PAD = GCNT_W - OFF_W;

    // Read offset and running count, with the read-side priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr <= '0;
            gcnt <= '0;
        end else if (unmap) begin
            rptr <= rptr;
        end else if (map_valid) begin
            rptr <= map_rptr;
            gcnt <= {{OFF_PAD{1'b0}}, map_rptr};
        end else if (rptr_load) begin
            rptr <= rptr_load_val;
            gcnt <= {{OFF_PAD{1'b0}}, rptr_load_val};
        end else if (adv_en) begin
            rptr <= adv_rptr;
            gcnt <= gcnt + {{LEN_PAD{1'b0}}, adv_len};
        end
    end

    // Write offset, taken from a map or from a doorbell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
        end else if (!unmap) begin
            if (map_valid)     wptr <= map_wptr;
            else if (db_valid) wptr <= db_wptr_red;
        end
    end

    // Mapped flag: an unmap clears it, a map sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)         valid <= 1'b0;
        else if (unmap)     valid <= 1'b0;
        else if (map_valid) valid <= 1'b1;
    end

    // Save strobe for one cycle, holding the offsets at the unmap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_valid <= 1'b0;
            save_rptr  <= '0;
            save_wptr  <= '0;
        end else begin
            save_valid <= unmap;
            if (unmap) begin
                save_rptr <= rptr;
                save_wptr <= wptr;
            end
        end
    end
endmodule

// File: rtl/rqt_fetch_ctl.sv
// Module: fetch control loop.
// Idle: a fetch request is raised when the queue is mapped and entries
// remain. Wait: the loop stays here until the consumer completes the packet.
// A completion returns the loop to idle, so the pointers are checked again.
// Assumes that map and unmap take priority over packet completion.
module rqt_fetch_ctl
    import rqt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic pending,
    input  logic pkt_done,
    input  logic unmap,
    input  logic map_valid,
    output logic fetch_req,
    output logic busy,
    output logic adv_en
);
    fc_state_e state;
    fc_state_e state_nx;

    // Decode the outputs and the next state from the current state.
    always_comb begin
        fetch_req = (state == FC_IDLE) && valid && pending && !unmap;
        adv_en    = (state == FC_WAIT) && pkt_done && !unmap && !map_valid;
        busy      = (state == FC_WAIT);
        state_nx  = state;
        if (unmap || map_valid)                  state_nx = FC_IDLE;
        else if (fetch_req)                      state_nx = FC_WAIT;
        else if (state == FC_WAIT && pkt_done)   state_nx = FC_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= FC_IDLE;
        else        state <= state_nx;
    end
endmodule

// File: rtl/ring_queue_tracker.sv
// Module: top of the ring queue pointer tracker.
// Connects the modular adders, the pointer registers and the fetch loop.
// Assumes that cfg_size is nonzero and stays stable while the queue is
// mapped, that pkt_len is below cfg_size, and that doorbell values are below
// twice cfg_size.
module ring_queue_tracker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int GCNT_W = 40,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [OFF_W-1:0]  cfg_size,
    input  logic              map_valid,
    input  logic [OFF_W-1:0]  map_rptr,
    input  logic [OFF_W-1:0]  map_wptr,
    input  logic              unmap,
    input  logic              rptr_load,
    input  logic [OFF_W-1:0]  rptr_load_val,
    input  logic              doorbell_valid,
    input  logic [OFF_W-1:0]  doorbell_wptr,
    input  logic              pkt_done,
    input  logic [LEN_W-1:0]  pkt_len,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] wptr_addr,
    output logic [OFF_W-1:0]  rptr_off,
    output logic [OFF_W-1:0]  wptr_off,
    output logic [GCNT_W-1:0] global_rptr,
    output logic              q_valid,
    output logic              q_busy,
    output logic              save_valid,
    output logic [OFF_W-1:0]  save_rptr,
    output logic [OFF_W-1:0]  save_wptr
);
    localparam int APAD = ADDR_W - OFF_W;
    localparam int LPAD = OFF_W - LEN_W;

    logic [OFF_W-1:0] db_red;
    logic [OFF_W-1:0] adv_rptr;
    logic [OFF_W-1:0] len_ext;
    logic             adv_en;
    logic             pending;

    // Widen the packet length to offset width.
    always_comb len_ext = {{LPAD{1'b0}}, pkt_len};

    rqt_modadd #(.W(OFF_W)) u_db_wrap (
        .a(doorbell_wptr), .b('0), .size(cfg_size), .y(db_red)
    );

    rqt_modadd #(.W(OFF_W)) u_rd_wrap (
        .a(rptr_off), .b(len_ext), .size(cfg_size), .y(adv_rptr)
    );

    rqt_ptr_regs #(.OFF_W(OFF_W), .GCNT_W(GCNT_W), .LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .map_valid(map_valid), .map_rptr(map_rptr), .map_wptr(map_wptr),
        .unmap(unmap), .rptr_load(rptr_load), .rptr_load_val(rptr_load_val),
        .db_valid(doorbell_valid), .db_wptr_red(db_red),
        .adv_en(adv_en), .adv_rptr(adv_rptr), .adv_len(pkt_len),
        .rptr(rptr_off), .wptr(wptr_off), .gcnt(global_rptr),
        .valid(q_valid), .save_valid(save_valid),
        .save_rptr(save_rptr), .save_wptr(save_wptr)
    );

    // Entries are waiting whenever the two offsets differ.
    always_comb pending = (rptr_off != wptr_off);

    rqt_fetch_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .valid(q_valid), .pending(pending),
        .pkt_done(pkt_done), .unmap(unmap), .map_valid(map_valid),
        .fetch_req(fetch_req), .busy(q_busy), .adv_en(adv_en)
    );

    // Addresses are formed from the base and the local offsets.
    always_comb begin
        fetch_addr = cfg_base + {{APAD{1'b0}}, rptr_off};
        wptr_addr  = cfg_base + {{APAD{1'b0}}, wptr_off};
    end
endmodule

// File: rtl/rqt_chk.sv
// Module: property checker for ring_queue_tracker, attached by bind.
module rqt_chk #(
    parameter int OFF_W  = 12,
    parameter int GCNT_W = 40,
    parameter int LEN_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OFF_W-1:0]  cfg_size,
    input logic              map_valid,
    input logic              unmap,
    input logic              rptr_load,
    input logic              pkt_done,
    input logic [LEN_W-1:0]  pkt_len,
    input logic              fetch_req,
    input logic [OFF_W-1:0]  rptr_off,
    input logic [OFF_W-1:0]  wptr_off,
    input logic [GCNT_W-1:0] global_rptr,
    input logic              q_valid,
    input logic              q_busy,
    input logic              save_valid,
    input logic [OFF_W-1:0]  save_rptr,
    input logic [OFF_W-1:0]  save_wptr
);
    // R4
    fetch_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !map_valid) |=> q_busy);

    // R6
    busy_no_refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_busy && !pkt_done && !map_valid && !unmap) |=> !fetch_req);

    // R7
    save_flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_valid |-> (!q_valid && !q_busy));

    // R7
    save_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unmap |=> (save_valid && save_rptr == $past(rptr_off)
                   && save_wptr == $past(wptr_off)));

    // R5
    gcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && q_busy && !unmap && !map_valid && !rptr_load)
        |=> (global_rptr == $past(global_rptr) + GCNT_W'($past(pkt_len))));

    // R3
    offsets_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |-> (rptr_off < cfg_size && wptr_off < cfg_size));
endmodule

bind ring_queue_tracker rqt_chk #(
    .OFF_W(OFF_W), .GCNT_W(GCNT_W), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/sim_ring_queue_tracker.sv
`timescale 1ns/1ps
module sim_ring_queue_tracker;
    localparam int AW = 32, OW = 12, GW = 40, LW = 8;
    localparam logic [AW-1:0] BASE = 32'h1000_0000;
    localparam logic [OW-1:0] SIZE = 12'd64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic map_valid = 0, unmap = 0, rptr_load = 0, doorbell_valid = 0, pkt_done = 0;
    logic [OW-1:0] map_rptr = 0, map_wptr = 0, rptr_load_val = 0, doorbell_wptr = 0;
    logic [LW-1:0] pkt_len = 0;
    logic fetch_req, q_valid, q_busy, save_valid;
    logic [AW-1:0] fetch_addr, wptr_addr;
    logic [OW-1:0] rptr_off, wptr_off, save_rptr, save_wptr;
    logic [GW-1:0] global_rptr;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [AW-1:0] exp_fetch[$];
    logic [2*OW-1:0] exp_save[$];

    always #10 clk = ~clk;

    ring_queue_tracker #(.ADDR_W(AW), .OFF_W(OW), .GCNT_W(GW), .LEN_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_base(BASE), .cfg_size(SIZE),
        .map_valid(map_valid), .map_rptr(map_rptr), .map_wptr(map_wptr),
        .unmap(unmap), .rptr_load(rptr_load), .rptr_load_val(rptr_load_val),
        .doorbell_valid(doorbell_valid), .doorbell_wptr(doorbell_wptr),
        .pkt_done(pkt_done), .pkt_len(pkt_len),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .wptr_addr(wptr_addr),
        .rptr_off(rptr_off), .wptr_off(wptr_off), .global_rptr(global_rptr),
        .q_valid(q_valid), .q_busy(q_busy), .save_valid(save_valid),
        .save_rptr(save_rptr), .save_wptr(save_wptr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pops the expected fetch and save items as the design emits them.
    always @(negedge clk) begin
        if (rst_n && fetch_req) begin
            if (exp_fetch.size() == 0) check("R4/R6/R9 unexpected fetch", {32'b0, fetch_addr}, 64'hFFFF);
            else check("R4 fetch_addr", {32'b0, fetch_addr}, {32'b0, exp_fetch.pop_front()});
        end
        if (rst_n && save_valid) begin
            if (exp_save.size() == 0) check("R7 unexpected save", 64'(save_rptr), 64'hFFFF);
            else check("R7 save offsets", 64'({save_rptr, save_wptr}), 64'(exp_save.pop_front()));
        end
    end

    task automatic pulse_db(input logic [OW-1:0] v);
        @(negedge clk); doorbell_valid = 1; doorbell_wptr = v;
        @(negedge clk); doorbell_valid = 0;
    endtask
    task automatic pulse_done(input logic [LW-1:0] n);
        @(negedge clk); pkt_done = 1; pkt_len = n;
        @(negedge clk); pkt_done = 0;
    endtask
    task automatic pulse_map(input logic [OW-1:0] r, input logic [OW-1:0] w);
        @(negedge clk); map_valid = 1; map_rptr = r; map_wptr = w;
        @(negedge clk); map_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 q_valid", 64'(q_valid), 0);
        check("R1 q_busy", 64'(q_busy), 0);
        check("R1 fetch_req", 64'(fetch_req), 0);
        check("R1 save_valid", 64'(save_valid), 0);
        check("R1 offsets", 64'({rptr_off, wptr_off}), 0);
        check("R1 global_rptr", 64'(global_rptr), 0);
        rst_n = 1;

        // R9 doorbell on unmapped queue: wptr moves, no fetch
        pulse_db(12'd5);
        check("R9 wptr_off", 64'(wptr_off), 5);
        @(negedge clk);
        check("R9 q_busy", 64'(q_busy), 0);

        // R2 map restores offsets and count
        pulse_map(12'd60, 12'd60);
        check("R2 q_valid", 64'(q_valid), 1);
        check("R2 rptr_off", 64'(rptr_off), 60);
        check("R2 wptr_off", 64'(wptr_off), 60);
        check("R2 global_rptr", 64'(global_rptr), 60);

        // R3 doorbell 70 reduces to 6, triggers R4 fetch at base+60
        exp_fetch.push_back(BASE + 60);
        pulse_db(12'd70);
        check("R3 wptr_off", 64'(wptr_off), 6);
        check("R3 wptr_addr", 64'(wptr_addr), 64'(BASE + 6));
        @(negedge clk);
        check("R4 q_busy", 64'(q_busy), 1);

        // R6 doorbell while busy: no new fetch
        pulse_db(12'd8);
        check("R6 wptr_off", 64'(wptr_off), 8);
        check("R6 still busy", 64'(q_busy), 1);

        // R5 wrap: 60+6 -> 2, count 66; R6 recheck fetches base+2
        exp_fetch.push_back(BASE + 2);
        pulse_done(8'd6);
        check("R5 rptr_off wrap", 64'(rptr_off), 2);
        check("R5 global_rptr", 64'(global_rptr), 66);
        @(negedge clk);
        pulse_done(8'd6);
        check("R5 rptr_off", 64'(rptr_off), 8);
        check("R5 global_rptr", 64'(global_rptr), 72);
        @(negedge clk);
        check("R6 idle when empty", 64'(q_busy), 0);

        // R5 completion while not busy is ignored
        pulse_done(8'd3);
        check("R5 ignored rptr", 64'(rptr_off), 8);
        check("R5 ignored count", 64'(global_rptr), 72);

        // R8 explicit load sets both offset and count
        exp_fetch.push_back(BASE + 20);
        @(negedge clk); rptr_load = 1; rptr_load_val = 12'd20;
        @(negedge clk); rptr_load = 0;
        check("R8 rptr_off", 64'(rptr_off), 20);
        check("R8 global_rptr", 64'(global_rptr), 20);
        @(negedge clk);
        check("R8 busy after fetch", 64'(q_busy), 1);

        // R7 unmap while busy
        exp_save.push_back({12'd20, 12'd8});
        @(negedge clk); unmap = 1;
        @(negedge clk); unmap = 0;
        check("R7 q_valid", 64'(q_valid), 0);
        check("R7 q_busy", 64'(q_busy), 0);
        @(negedge clk);
        check("R7 save one cycle", 64'(save_valid), 0);
        check("R7 offsets kept", 64'({rptr_off, wptr_off}), 64'({12'd20, 12'd8}));

        // R2 remap with saved values resumes at base+20
        exp_fetch.push_back(BASE + 20);
        pulse_map(save_rptr, save_wptr);
        check("R2 remap rptr", 64'(rptr_off), 20);
        check("R2 remap count", 64'(global_rptr), 20);
        @(negedge clk);
        check("R2 remap busy", 64'(q_busy), 1);

        repeat (2) @(negedge clk);
        check("R4 all fetches seen", 64'(exp_fetch.size()), 0);
        check("R7 all saves seen", 64'(exp_save.size()), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule